// File: doc/BRIEF.md
# Hot-Plug Detect Interrupt Unit

This block watches the hot-plug detect line coming back from a display sink. That line is asynchronous to the block's clock. The block brings it into the clock domain and removes glitches with a programmable stability filter. From the filtered level it keeps a live connection status. It also turns each accepted transition into a separate event: one for a plug-in (rising edge) and one for an unplug (falling edge).

These two events are latched into a sticky status register. The interrupt request of an attached transmitter core is latched into the same register, so all three sources share one clear mechanism and one enable mechanism.

Software works through a small word-addressed register port. It can read the latched status, clear bits by writing ones, set a per-source enable, program the filter and read the live level. A single interrupt line leaves the block. It stays high while any enabled status bit is set.

Top module: `hpd_irq_unit`

## Requirements
- R1: After reset the latched status, the enable mask, the live level and `irq_o` are all zero, and the filter word reads 0x0000A0A0.
- R2: Suppose the hot-plug input goes high and stays high long enough to pass the filter. Then status bit 1 (plug-in event) becomes set, and the level register (address 4) reads 1.
- R3: After a filtered high-to-low change, status bit 2 (unplug event) becomes set and the level register reads 0. A plug-in event and an unplug event are never flagged in the same cycle.
- R4: A hot-plug pulse that is shorter than the filter window has no effect. It leaves both the status and the level register unchanged.
- R5: A cycle with `core_irq_i` high sets status bit 0.
- R6: A write to the clear address (1) clears exactly the status bits written as one. All other bits keep their value, and the clear address reads as zero.
- R7: If a source sets a status bit in the same cycle that the bit is cleared, the bit stays set.
- R8: `irq_o` is a registered level. It is high exactly when some status bit is set and its enable bit (enable register at address 2, bits [2:0]) is one. A disabled source still latches its status bit but does not raise `irq_o`.
- R9: The filter word at address 3 has two fields. Bits [11:0] hold a tick count N, and bits [15:12] hold an exponent E. Each tick lasts 2^E clock cycles. The filtered level changes only after the synchronised input has differed from it for N consecutive ticks.
- R10: The enable register keeps only bits [2:0], and the filter word keeps only bits [15:0]. The status register is at address 0. Reads return the value one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| hpd_raw_i | input | 1 | Asynchronous hot-plug detect line from the sink |
| core_irq_i | input | 1 | Interrupt request from the transmitter core, synchronous to clk |
| reg_wen_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Registered read data for the previous cycle's address |
| irq_o | output | 1 | Combined level interrupt |

## Verification
The assertions assume that `core_irq_i` and the register strobes are synchronous to `clk`. They also assume that only the hot-plug line may change at arbitrary times, and that reset is held for at least one edge before any stimulus. The bench changes every input half a cycle away from the active edge. It keeps `core_irq_i` low during reset. It programs a short filter window before it drives any hot-plug transitions, so that every accepted or rejected pulse lies well clear of the window boundary. Under the exponent setting, a pulse is either a few ticks short of the window or comfortably longer than it, so the prescaler phase cannot decide the outcome.

// File: rtl/hpd_irq_pkg.sv
package hpd_irq_pkg;
  localparam int ADDR_STAT  = 0;
  localparam int ADDR_CLR   = 1;
  localparam int ADDR_MASK  = 2;
  localparam int ADDR_CFG   = 3;
  localparam int ADDR_LEVEL = 4;

  localparam int SRC_CORE = 0;
  localparam int SRC_RISE = 1;
  localparam int SRC_FALL = 2;
  localparam int N_SRC    = 3;

  localparam logic [15:0] CFG_DEFAULT = 16'hA0A0;
endpackage

// File: rtl/hpd_sync_filter.sv
module hpd_sync_filter #(
  parameter int CNT_W = 12,
  parameter int EXP_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             raw_i,
  input  logic [CNT_W-1:0] win_i,
  input  logic [EXP_W-1:0] exp_i,
  output logic             level_o,
  output logic             rise_o,
  output logic             fall_o
);
  localparam int PRE_W = (1 << EXP_W) - 1;

  logic             s1_q, s2_q, filt_q;
  logic [CNT_W-1:0] cnt_q;
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] pre_mask;
  logic [CNT_W-1:0] limit;
  logic             tick;

  assign pre_mask = ~({PRE_W{1'b1}} << exp_i);
  assign tick     = (pre_q & pre_mask) == pre_mask;
  assign limit    = (win_i == '0) ? '0 : win_i - 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      filt_q <= 1'b0;
      cnt_q  <= '0;
      pre_q  <= '0;
      rise_o <= 1'b0;
      fall_o <= 1'b0;
    end else begin
      s1_q   <= raw_i;
      s2_q   <= s1_q;
      pre_q  <= pre_q + 1'b1;
      rise_o <= 1'b0;
      fall_o <= 1'b0;
      if (s2_q == filt_q) begin
        cnt_q <= '0;
      end else if (tick) begin
        if (cnt_q >= limit) begin
          filt_q <= s2_q;
          cnt_q  <= '0;
          rise_o <= s2_q;
          fall_o <= ~s2_q;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign level_o = filt_q;

  assert_level_follows_sync_R9: assert property (@(posedge clk) disable iff (rst)
    (filt_q != $past(filt_q)) |-> (filt_q == $past(s2_q)));
  assert_rise_marks_up_R2: assert property (@(posedge clk) disable iff (rst)
    rise_o |-> (filt_q && !$past(filt_q)));
  assert_edges_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rise_o, fall_o}));
endmodule

// File: rtl/hpd_event_latch.sv
module hpd_event_latch #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] stat_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)           stat_o[i] <= 1'b0;
      else if (set_i[i]) stat_o[i] <= 1'b1;
      else if (clr_i[i]) stat_o[i] <= 1'b0;
    end
  end

  assert_set_beats_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (|$past(set_i)) |-> ((stat_o & $past(set_i)) == $past(set_i)));
  assert_clear_only_written_R6: assert property (@(posedge clk) disable iff (rst)
    ((stat_o ^ $past(stat_o)) & ~($past(clr_i) | $past(set_i))) == '0);
endmodule

// File: rtl/hpd_reg_port.sv
module hpd_reg_port
  import hpd_irq_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32,
  parameter int CFG_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wen_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [N_SRC-1:0]  stat_i,
  input  logic              level_i,
  output logic [N_SRC-1:0]  mask_o,
  output logic [CFG_W-1:0]  cfg_o,
  output logic [N_SRC-1:0]  clr_o
);
  logic [DATA_W-1:0] rd_mux;

  assign clr_o = (wen_i && addr_i == ADDR_W'(ADDR_CLR)) ? wdata_i[N_SRC-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_o <= '0;
      cfg_o  <= CFG_W'(CFG_DEFAULT);
    end else if (wen_i) begin
      if (addr_i == ADDR_W'(ADDR_MASK)) mask_o <= wdata_i[N_SRC-1:0];
      if (addr_i == ADDR_W'(ADDR_CFG))  cfg_o  <= wdata_i[CFG_W-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr_i)
      ADDR_W'(ADDR_STAT):  rd_mux = DATA_W'(stat_i);
      ADDR_W'(ADDR_MASK):  rd_mux = DATA_W'(mask_o);
      ADDR_W'(ADDR_CFG):   rd_mux = DATA_W'(cfg_o);
      ADDR_W'(ADDR_LEVEL): rd_mux = DATA_W'(level_i);
      default:             rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_o <= '0;
    else     rdata_o <= rd_mux;
  end

  assert_mask_holds_R10: assert property (@(posedge clk) disable iff (rst)
    !$past(wen_i) |-> $stable(mask_o));
endmodule

// File: rtl/hpd_irq_unit.sv
module hpd_irq_unit
  import hpd_irq_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 12,
  parameter int EXP_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hpd_raw_i,
  input  logic              core_irq_i,
  input  logic              reg_wen_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  localparam int CFG_W = CNT_W + EXP_W;

  logic [N_SRC-1:0] stat, mask, clr, set_v;
  logic [CFG_W-1:0] cfg;
  logic             level, rise, fall;

  hpd_sync_filter #(.CNT_W(CNT_W), .EXP_W(EXP_W)) u_filt (
    .clk(clk), .rst(rst), .raw_i(hpd_raw_i),
    .win_i(cfg[CNT_W-1:0]), .exp_i(cfg[CFG_W-1:CNT_W]),
    .level_o(level), .rise_o(rise), .fall_o(fall)
  );

  always_comb begin
    set_v           = '0;
    set_v[SRC_CORE] = core_irq_i;
    set_v[SRC_RISE] = rise;
    set_v[SRC_FALL] = fall;
  end

  hpd_event_latch #(.N(N_SRC)) u_latch (
    .clk(clk), .rst(rst), .set_i(set_v), .clr_i(clr), .stat_o(stat)
  );

  hpd_reg_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CFG_W(CFG_W)) u_regs (
    .clk(clk), .rst(rst), .wen_i(reg_wen_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o), .stat_i(stat),
    .level_i(level), .mask_o(mask), .cfg_o(cfg), .clr_o(clr)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= |(stat & mask);
  end

  assert_irq_needs_status_R8: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (|$past(stat)));
endmodule

// File: tb/hpd_irq_unit_bench.sv
module hpd_irq_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hpd = 1'b0;
  logic        core = 1'b0;
  logic        wen = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hpd_irq_unit u_hpd_irq_unit (
    .clk(clk), .rst(rst), .hpd_raw_i(hpd), .core_irq_i(core),
    .reg_wen_i(wen), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  // vector: {address, write data, expected readback}
  localparam logic [66:0] VEC [6] = '{
    {3'd2, 32'h0000_0007, 32'h0000_0007},
    {3'd2, 32'hFFFF_FFFF, 32'h0000_0007},
    {3'd3, 32'h0001_2345, 32'h0000_2345},
    {3'd1, 32'h0000_00FF, 32'h0000_0000},
    {3'd3, 32'h0000_0008, 32'h0000_0008},
    {3'd2, 32'h0000_0000, 32'h0000_0000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wen = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wen = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    d = rdata;
  endtask

  initial begin
    logic [31:0] v;
    cyc(3);
    rst = 1'b0;
    cyc(1);
    rd(3'd0, v); chk("R1 status", v, 32'h0);
    rd(3'd2, v); chk("R1 mask", v, 32'h0);
    rd(3'd3, v); chk("R1 cfg", v, 32'h0000A0A0);
    rd(3'd4, v); chk("R1 level", v, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);

    for (int i = 0; i < 6; i++) begin
      wr(VEC[i][66:64], VEC[i][63:32]);
      rd(VEC[i][66:64], v);
      chk("R10 R6 readback", v, VEC[i][31:0]);
    end

    // filter: E=0, N=8; 5-cycle glitch rejected
    @(negedge clk); hpd = 1'b1; cyc(5); hpd = 1'b0; cyc(20);
    rd(3'd0, v); chk("R4 glitch status", v, 32'h0);
    rd(3'd4, v); chk("R4 glitch level", v, 32'h0);

    hpd = 1'b1; cyc(20);
    rd(3'd4, v); chk("R2 level high", v, 32'h1);
    rd(3'd0, v); chk("R2 rise bit", v, 32'h2);
    chk("R8 masked no irq", {31'b0, irq}, 32'h0);

    wr(3'd2, 32'h2); cyc(3);
    chk("R8 irq enabled", {31'b0, irq}, 32'h1);
    wr(3'd1, 32'h2); cyc(3);
    chk("R8 irq drops after clear", {31'b0, irq}, 32'h0);
    rd(3'd0, v); chk("R6 cleared rise", v, 32'h0);

    hpd = 1'b0; cyc(20);
    rd(3'd0, v); chk("R3 fall bit", v, 32'h4);
    rd(3'd4, v); chk("R3 level low", v, 32'h0);

    core = 1'b1; cyc(1); core = 1'b0; cyc(1);
    rd(3'd0, v); chk("R5 core bit", v, 32'h5);
    wr(3'd1, 32'h1);
    rd(3'd0, v); chk("R6 partial clear", v, 32'h4);
    wr(3'd1, 32'h4);
    rd(3'd0, v); chk("R6 full clear", v, 32'h0);

    core = 1'b1; cyc(1);
    wr(3'd1, 32'h1);
    rd(3'd0, v); chk("R7 set wins", v, 32'h1);
    core = 1'b0;
    wr(3'd1, 32'h1);
    rd(3'd0, v); chk("R7 clear after release", v, 32'h0);

    // exponent: E=2, N=4 -> 16-cycle window
    wr(3'd3, 32'h0000_2004);
    hpd = 1'b1; cyc(10); hpd = 1'b0; cyc(40);
    rd(3'd4, v); chk("R9 short pulse level", v, 32'h0);
    rd(3'd0, v); chk("R9 short pulse status", v, 32'h0);
    hpd = 1'b1; cyc(40);
    rd(3'd4, v); chk("R9 long pulse level", v, 32'h1);
    rd(3'd0, v); chk("R9 long pulse status", v, 32'h2);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule